// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit fixed-point coefficients in parallel lanes. It keeps a rounded 16-bit fraction of each product. It serves a media datapath: a caller presents a variant code and two 64-bit operands with a one-cycle start strobe. Two cycles later the block returns a packed 64-bit result together with a one-cycle done flag.

Every product is formed as a 9-bit signed value (the byte, zero-extended) times a 16-bit signed coefficient, which gives a 25-bit intermediate. The kept field is product bits [23:8], rounded up when bit 7 is set. The variants differ in two ways. The first is where each lane's byte and coefficient come from: per-lane coefficients, one shared coefficient, or the upper or lower byte of each 16-bit lane of the first operand. The second is how results are packed: four 16-bit lanes, or two widened 32-bit lanes.

Top module: `pmul_frac8x16`

## Requirements
- R1: After a reset cycle, result is all zero and done is low until an operation completes.
- R2: When start is high at a rising edge, done is high for exactly the cycle that begins two rising edges later. Mode and operands are taken only at the start edge. Done never rises without a start two edges earlier.
- R3: Mode 0 (per-lane): for lane i of 0..3, result[16i+15:16i] = F(opa[8i+7:8i], opb[16i+15:16i]). Here F(p,c) is the scaled product of unsigned byte p and signed coefficient c.
- R4: F(p,c) = ((p*c) >> 8) + bit 7 of p*c, computed on the signed product with an arithmetic shift and kept modulo 2^16. For example, F(1,0x0080)=0x0001, F(1,0x007F)=0x0000, F(0xFF,0xFFFF)=0xFFFF and F(2,0xFFC0)=0x0000.
- R5: Mode 1 (shared high coefficient): lane i = F(opa[8i+7:8i], opb[31:16]) for i of 0..3.
- R6: Mode 2 (shared low coefficient): lane i = F(opa[8i+7:8i], opb[15:0]) for i of 0..3.
- R7: Mode 3 (upper byte): lane i = F(opa[16i+15:16i+8], opb[16i+15:16i]) for i of 0..3.
- R8: Mode 4 (lower byte): lane i = F(opa[16i+7:16i], opb[16i+15:16i]) for i of 0..3.
- R9: Modes 5 (upper byte) and 6 (lower byte) are widened. For j of 0..1, result[32j+22:32j+7] = F(byte, opb[16j+15:16j]). The byte is opa[16j+15:16j+8] in mode 5 and opa[16j+7:16j] in mode 6. Bits [32j+6:32j] and [32j+31:32j+23] are zero.
- R10: Mode 7 yields an all-zero result. In modes 0, 1, 2, 5 and 6, opa[63:32] has no effect on the result.
- R11: The result holds its value in every cycle where done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins an operation on the current mode and operands |
| mode | input | 3 | Variant code, 0 to 7 as listed in the requirements |
| opa | input | 64 | Pixel operand (bytes) |
| opb | input | 64 | Coefficient operand (signed 16-bit fields) |
| result | output | 64 | Packed scaled products |
| done | output | 1 | One-cycle flag marking a new result |

## Verification
The bound checker watches on every cycle the latency relation between start and done in both directions, the clean state after reset, and that result holds while done is low. For every completed widened or reserved operation it also checks that the unused bit fields are zero. The arithmetic itself can only be shown by the bench's scenarios. These sweep every byte value through each variant against sixteen coefficients that include the signed extremes and the rounding boundary. Further directed scenarios show that rounding hits its exact edges and that the upper half of the pixel operand is ignored where the requirements say so.

// File: rtl/pmul_pkg.sv
// Shared definitions for the partitioned fractional multiplier.
// Assumes the variant code is three bits wide and decoded the same way in every stage.
package pmul_pkg;

    typedef enum logic [2:0] {
        PM_BASIC    = 3'd0,
        PM_SHARE_HI = 3'd1,
        PM_SHARE_LO = 3'd2,
        PM_HI_BYTE  = 3'd3,
        PM_LO_BYTE  = 3'd4,
        PM_WIDE_HI  = 3'd5,
        PM_WIDE_LO  = 3'd6,
        PM_RSVD     = 3'd7
    } pm_mode_e;

endpackage

// File: rtl/pmul_operand_route.sv
// Operand router: selects, for each lane, the unsigned pixel byte and the
// signed coefficient that the active variant multiplies. Purely combinational.
// Assumes COEF_W >= 2*PIX_W so that both bytes of a coefficient-wide lane exist.
// Lanes a variant leaves unused receive zero operands.
module pmul_operand_route
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  pm_mode_e                        mode,
    input  logic [LANES*COEF_W-1:0]         opa,
    input  logic [LANES*COEF_W-1:0]         opb,
    output logic [LANES-1:0][PIX_W-1:0]     pix,
    output logic [LANES-1:0][COEF_W-1:0]    coef
);

    localparam int WIDE_LANES = LANES / 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit IN_WIDE = (g < WIDE_LANES);

        logic [PIX_W-1:0]  pix_l;
        logic [COEF_W-1:0] coef_l;
        logic [PIX_W-1:0]  byte_packed;
        logic [PIX_W-1:0]  byte_hi;
        logic [PIX_W-1:0]  byte_lo;
        logic [COEF_W-1:0] coef_own;

        assign byte_packed = opa[g*PIX_W +: PIX_W];
        assign byte_hi     = opa[g*COEF_W + PIX_W +: PIX_W];
        assign byte_lo     = opa[g*COEF_W +: PIX_W];
        assign coef_own    = opb[g*COEF_W +: COEF_W];

        // Lane operand choice by variant
        always_comb begin
            pix_l  = '0;
            coef_l = '0;
            case (mode)
                PM_BASIC: begin
                    pix_l  = byte_packed;
                    coef_l = coef_own;
                end
                PM_SHARE_HI: begin
                    pix_l  = byte_packed;
                    coef_l = opb[COEF_W +: COEF_W];
                end
                PM_SHARE_LO: begin
                    pix_l  = byte_packed;
                    coef_l = opb[0 +: COEF_W];
                end
                PM_HI_BYTE: begin
                    pix_l  = byte_hi;
                    coef_l = coef_own;
                end
                PM_LO_BYTE: begin
                    pix_l  = byte_lo;
                    coef_l = coef_own;
                end
                PM_WIDE_HI: begin
                    if (IN_WIDE) begin
                        pix_l  = byte_hi;
                        coef_l = coef_own;
                    end
                end
                PM_WIDE_LO: begin
                    if (IN_WIDE) begin
                        pix_l  = byte_lo;
                        coef_l = coef_own;
                    end
                end
                default: begin
                    pix_l  = '0;
                    coef_l = '0;
                end
            endcase
        end

        assign pix[g]  = pix_l;
        assign coef[g] = coef_l;
    end

endmodule

// File: rtl/pmul_mult_stage.sv
// First pipeline stage: forms a full signed product per lane (zero-extended
// pixel times signed coefficient) and registers it with the variant code.
// Assumes PROD_W = PIX_W + 1 + COEF_W holds every product exactly.
module pmul_mult_stage
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  pm_mode_e                                in_mode,
    input  logic [LANES-1:0][PIX_W-1:0]             pix,
    input  logic [LANES-1:0][COEF_W-1:0]            coef,
    output logic                                    out_valid,
    output pm_mode_e                                out_mode,
    output logic [LANES-1:0][PIX_W+COEF_W:0]        prod
);

    localparam int PROD_W = PIX_W + 1 + COEF_W;

    for (genvar g = 0; g < LANES; g++) begin : g_mul
        logic signed [PROD_W-1:0] pix_ext;
        logic signed [PROD_W-1:0] coef_ext;
        logic signed [PROD_W-1:0] prod_c;

        assign pix_ext  = PROD_W'({1'b0, pix[g]});
        assign coef_ext = PROD_W'($signed(coef[g]));
        assign prod_c   = pix_ext * coef_ext;

        // Capture this lane's product
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod[g] <= '0;
            end else if (in_valid) begin
                prod[g] <= prod_c;
            end
        end
    end

    // Carry valid and variant alongside the products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mode  <= PM_BASIC;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mode <= in_mode;
            end
        end
    end

endmodule

// File: rtl/pmul_pack_stage.sv
// Second pipeline stage: takes the middle field of each product with
// round-half-up on the first dropped bit, then packs the lanes by variant
// into the output word. Unwritten bits are zero.
// Assumes the widened lanes are twice COEF_W and hold COEF_W + PIX_W - 1 bits.
module pmul_pack_stage
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  pm_mode_e                            in_mode,
    input  logic [LANES-1:0][PIX_W+COEF_W:0]    prod,
    output logic [LANES*COEF_W-1:0]             result,
    output logic                                done
);

    localparam int DATA_W     = LANES * COEF_W;
    localparam int WIDE_LANES = LANES / 2;
    localparam int WIDE_W     = 2 * COEF_W;
    localparam int WIDE_SHIFT = PIX_W - 1;
    localparam int WIDE_PAD   = WIDE_W - COEF_W - WIDE_SHIFT;

    logic [LANES-1:0][COEF_W-1:0] kept;
    logic [DATA_W-1:0]            packed_c;

    for (genvar g = 0; g < LANES; g++) begin : g_round
        logic [COEF_W-1:0] field;
        logic [COEF_W-1:0] bump;

        assign field   = prod[g][PIX_W+COEF_W-1:PIX_W];
        assign bump    = COEF_W'(prod[g][PIX_W-1]);
        assign kept[g] = field + bump;
    end

    // Lane packing by variant
    always_comb begin
        packed_c = '0;
        case (in_mode)
            PM_WIDE_HI, PM_WIDE_LO: begin
                for (int j = 0; j < WIDE_LANES; j++) begin
                    packed_c[j*WIDE_W +: WIDE_W] =
                        {{WIDE_PAD{1'b0}}, kept[j], {WIDE_SHIFT{1'b0}}};
                end
            end
            PM_RSVD: begin
                packed_c = '0;
            end
            default: begin
                for (int i = 0; i < LANES; i++) begin
                    packed_c[i*COEF_W +: COEF_W] = kept[i];
                end
            end
        endcase
    end

    // Output register: update on a completed operation, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                result <= packed_c;
            end
        end
    end

endmodule

// File: rtl/pmul_frac8x16.sv
// Top of the partitioned 8x16 fractional multiplier. Routes operands by
// variant, multiplies in stage one, rounds and packs in stage two.
// A start strobe yields done and a fresh result two rising edges later.
// Assumes synchronous active-low reset and a start of one cycle per operation.
module pmul_frac8x16
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [2:0]                  mode,
    input  logic [LANES*COEF_W-1:0]     opa,
    input  logic [LANES*COEF_W-1:0]     opb,
    output logic [LANES*COEF_W-1:0]     result,
    output logic                        done
);

    localparam int PROD_W = PIX_W + 1 + COEF_W;

    pm_mode_e                       mode_in;
    logic [LANES-1:0][PIX_W-1:0]    pix;
    logic [LANES-1:0][COEF_W-1:0]   coef;
    logic                           s1_valid;
    pm_mode_e                       s1_mode;
    logic [LANES-1:0][PROD_W-1:0]   s1_prod;

    assign mode_in = pm_mode_e'(mode);

    pmul_operand_route #(
        .LANES  (LANES),
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W)
    ) u_route (
        .mode (mode_in),
        .opa  (opa),
        .opb  (opb),
        .pix  (pix),
        .coef (coef)
    );

    pmul_mult_stage #(
        .LANES  (LANES),
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W)
    ) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (start),
        .in_mode   (mode_in),
        .pix       (pix),
        .coef      (coef),
        .out_valid (s1_valid),
        .out_mode  (s1_mode),
        .prod      (s1_prod)
    );

    pmul_pack_stage #(
        .LANES  (LANES),
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s1_valid),
        .in_mode  (s1_mode),
        .prod     (s1_prod),
        .result   (result),
        .done     (done)
    );

endmodule

// File: rtl/pmul_frac8x16_chk.sv
// Protocol and packing checker for pmul_frac8x16, attached by bind.
// Keeps a small saturating count of cycles since reset so that no
// property looks back past the reset.
module pmul_frac8x16_chk #(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic [2:0]               mode,
    input logic [LANES*COEF_W-1:0]  result,
    input logic                     done
);

    localparam int WIDE_LANES = LANES / 2;
    localparam int WIDE_W     = 2 * COEF_W;
    localparam int WIDE_SHIFT = PIX_W - 1;
    localparam int WIDE_PAD   = WIDE_W - COEF_W - WIDE_SHIFT;

    logic [1:0] age;

    // Saturating count of edges since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> (result == '0 && !done));

    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done);

    a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && done) |-> $past(start, 2));

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && !done) |-> $stable(result));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && done && $past(mode, 2) == 3'd7) |-> (result == '0));

    for (genvar j = 0; j < WIDE_LANES; j++) begin : g_wide
        a_r9_wide_pad: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && done && ($past(mode, 2) == 3'd5 || $past(mode, 2) == 3'd6))
            |-> (result[j*WIDE_W +: WIDE_SHIFT] == '0 &&
                 result[j*WIDE_W + WIDE_SHIFT + COEF_W +: WIDE_PAD] == '0));
    end

endmodule

bind pmul_frac8x16 pmul_frac8x16_chk #(
    .LANES  (LANES),
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .result (result),
    .done   (done)
);

// File: tb/sim_pmul_frac8x16.sv
`timescale 1ns/1ps
module sim_pmul_frac8x16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] result;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    pmul_frac8x16 u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .opa    (opa),
        .opb    (opb),
        .result (result),
        .done   (done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scaled product per R4
    function automatic logic [15:0] fr(input logic [7:0] p, input logic [15:0] c);
        integer pi, ci, prod;
        pi   = p;
        ci   = $signed(c);
        prod = pi * ci;
        return 16'((prod >>> 8) + ((prod >>> 7) & 1));
    endfunction

    // Expected result per R3, R5-R10
    function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        case (m)
            3'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = fr(a[8*i +: 8], b[16*i +: 16]);
            3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = fr(a[8*i +: 8], b[31:16]);
            3'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = fr(a[8*i +: 8], b[15:0]);
            3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = fr(a[16*i+8 +: 8], b[16*i +: 16]);
            3'd4: for (int i = 0; i < 4; i++) r[16*i +: 16] = fr(a[16*i +: 8], b[16*i +: 16]);
            3'd5: for (int j = 0; j < 2; j++) r[32*j+7 +: 16] = fr(a[16*j+8 +: 8], b[16*j +: 16]);
            3'd6: for (int j = 0; j < 2; j++) r[32*j+7 +: 16] = fr(a[16*j +: 8], b[16*j +: 16]);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] coef_at(input int idx);
        case (idx % 16)
            0: return 16'h0000;   1: return 16'h0001;   2: return 16'h0080;   3: return 16'h00FF;
            4: return 16'h0100;   5: return 16'h7FFF;   6: return 16'h8000;   7: return 16'h8001;
            8: return 16'hFFFF;   9: return 16'hFF00;  10: return 16'hFF80;  11: return 16'h1234;
            12: return 16'hC0DE; 13: return 16'h5555; 14: return 16'hAAAA;  15: return 16'h0007;
            default: return 16'h0000;
        endcase
    endfunction

    // One operation: start at a falling edge, check done latency (R2) and result
    task automatic do_op(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] res);
        logic [63:0] e;
        e = model(m, a, b);
        mode  = m;
        opa   = a;
        opb   = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        opa   = ~a;
        opb   = ~b;
        mode  = m + 3'd1;
        chk("R2 done early", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R2 done late", {63'd0, done}, 64'd1);
        chk(tag(m), result, e);
        res = result;
    endtask

    initial begin
        logic [63:0] r, r2, held;

        repeat (4) @(negedge clk);
        chk("R1 result in reset", result, 64'd0);
        chk("R1 done in reset", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 result after reset", result, 64'd0);
        chk("R1 done after reset", {63'd0, done}, 64'd0);

        // R4 rounding edges, basic mode lane 0
        do_op(3'd0, 64'h01, 64'h0080, r);
        chk("R4 round up", {48'd0, r[15:0]}, 64'h0001);
        do_op(3'd0, 64'h01, 64'h007F, r);
        chk("R4 below half", {48'd0, r[15:0]}, 64'h0000);
        do_op(3'd0, 64'hFF, 64'hFFFF, r);
        chk("R4 negative no bump", {48'd0, r[15:0]}, 64'hFFFF);
        do_op(3'd0, 64'h02, 64'hFFC0, r);
        chk("R4 negative bump to zero", {48'd0, r[15:0]}, 64'h0000);

        // R10 upper pixel half ignored in modes 0,1,2,5,6
        for (int m = 0; m < 7; m++) begin
            if (m != 3 && m != 4) begin
                do_op(3'(m), 64'h0000_0000_9C3F_80FE, 64'h8001_7FFF_FF80_1234, r);
                do_op(3'(m), 64'hFFFF_FFFF_9C3F_80FE, 64'h8001_7FFF_FF80_1234, r2);
                chk("R10 upper half ignored", r2, r);
            end
        end

        // R11 hold while idle, with inputs changing
        do_op(3'd0, 64'h0000_0000_7F80_01FF, 64'h7FFF_8000_0100_FFFF, held);
        for (int c = 0; c < 6; c++) begin
            opa  = {8{8'(c * 53 + 1)}};
            opb  = {4{16'(c * 4099 + 7)}};
            mode = 3'(c);
            @(negedge clk);
            chk("R11 result held", result, held);
            chk("R11 no done", {63'd0, done}, 64'd0);
        end

        // Near-exhaustive sweep: every byte value, all variants, sixteen coefficients
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 16; k++) begin
                for (int v = 0; v < 256; v++) begin
                    logic [63:0] a, b;
                    for (int i = 0; i < 8; i++) a[8*i +: 8] = 8'(v + 29 * i + 3 * k);
                    for (int i = 0; i < 4; i++) b[16*i +: 16] = coef_at(k + 5 * i);
                    do_op(3'(m), a, b, r);
                end
            end
        end

        @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule